// File: doc/BRIEF.md
# Converter Register Target on a Two-Wire Serial Bus

This block is the serial-bus target side of a small data converter. It watches the clock and data lines of a two-wire open-drain bus and passes both through synchronisers clocked by a much faster system clock. It then finds bus conditions and shifts bytes MSB first. When the master reads, it returns the 16-bit conversion result (high byte, then low byte) followed by the configuration byte. When the master writes, each received byte goes to the converter's configuration logic as a one-cycle strobe.

The block also handles two bus-wide addresses. The all-zero general-call address is always acknowledged. A following data byte of 06h raises a reset pulse for the converter. The high-speed master code (00001xxx) is never acknowledged and turns on a high-speed flag that lasts until the next stop. The block drives the data line only by pulling it low, and never drives the clock line.

Top module: `i2c_conv_target`

## Requirements
- R1: An address byte whose upper seven bits equal 1001000 is acknowledged: the target pulls data low during the ninth clock of that byte. Bit 0 selects direction (1 = read, 0 = write).
- R2: A stop condition (data rising while clock is high) returns the block to idle, releases the data line and clears the high-speed flag. A start condition (data falling while clock is high) begins an address phase.
- R3: A read returns the result bits 15:8, then result bits 7:0, then the configuration byte, each MSB first. The result is captured when the read address is accepted.
- R4: Read bytes after the third return FFh because the data line is left released, and they change no converter-facing output.
- R5: In a write, each data byte appears on the configuration data output with a one-cycle strobe once its eighth bit has been clocked in, and the byte is acknowledged.
- R6: The general-call address 00h is always acknowledged. A following data byte 06h is acknowledged and produces one general-call reset pulse.
- R7: After the general-call address, a data byte of 04h is acknowledged with no reset pulse. Any data byte other than 04h or 06h is not acknowledged and produces no reset pulse.
- R8: An address byte matching 00001xxx is never acknowledged and sets the high-speed flag, which stays set until the next stop.
- R9: A start issued while the bus is active (repeated start) begins a new address phase, so a read may follow a write without a stop.
- R10: After an address byte that matches none of the above, the block never pulls the data line low until the next start or stop.
- R11: After reset the data line is released, the high-speed flag is clear and neither strobe is asserted.
- R12: A master not-acknowledge after a read byte ends the read: the data line stays released for the rest of the transfer.
- R13: The data-line drive changes only in the cycle after a clock falling edge, start or stop seen on the synchronised lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| result_i | input | 16 | Latest conversion result, two's complement |
| cfg_rd_i | input | 8 | Configuration byte returned as the third read byte |
| cfg_wr_o | output | 1 | One-cycle strobe for a received write byte |
| cfg_data_o | output | 8 | Received write byte, valid with the strobe |
| gc_reset_o | output | 1 | One-cycle general-call reset pulse |
| hs_mode_o | output | 1 | High-speed mode flag |

## Verification
The bench goes after the edges of the read sequence. A design that miscounts bytes would send the configuration byte too early, or would keep pulling data low past the third byte and show a value other than FFh. It sends general-call data bytes 04h, 06h and an unlisted value: a decoder that is too loose would acknowledge the unlisted byte or pulse reset on 04h. Foreign addresses and the master code are checked while the data line is watched on every cycle, because a target that still acknowledges after a mismatch would corrupt other devices' transfers. A repeated start after a write must lead to a correct read; a design that ignores a start while active would go on treating the read address as write data.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WRITE,
    ST_READ,
    ST_GCALL,
    ST_SKIP
  } tgt_state_t;

  localparam logic [7:0] GC_ADDR_BYTE = 8'h00;
  localparam logic [7:0] GC_RESET_CMD = 8'h06;
  localparam logic [7:0] GC_LATCH_CMD = 8'h04;

  // Byte presented for read slot idx: result high, result low, config, then idle-high.
  function automatic logic [7:0] rd_byte(input logic [1:0] idx,
                                         input logic [15:0] res,
                                         input logic [7:0] cfg);
    case (idx)
      2'd0:    rd_byte = res[15:8];
      2'd1:    rd_byte = res[7:0];
      2'd2:    rd_byte = cfg;
      default: rd_byte = 8'hFF;
    endcase
  endfunction

  function automatic logic is_master_code(input logic [7:0] b);
    is_master_code = (b[7:3] == 5'b00001);
  endfunction

  function automatic logic gc_data_acked(input logic [7:0] b);
    gc_data_acked = (b == GC_RESET_CMD) || (b == GC_LATCH_CMD);
  endfunction

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2ct_ctrl.sv
module i2ct_ctrl
  import i2ct_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1001000,
  parameter int         RES_W    = 16,
  parameter int         CFG_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [RES_W-1:0] result_i,
  input  logic [CFG_W-1:0] cfg_rd_i,
  output logic             sda_oe,
  output logic             wr_stb,
  output logic [CFG_W-1:0] wr_data,
  output logic             gc_rst,
  output logic             hs_mode
);
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(7);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(8);

  tgt_state_t       st, nxt;
  logic [CNT_W-1:0] bitcnt;
  logic             in_ack, ack_ok, mack;
  logic [7:0]       rx_sh, tx_sh;
  logic [1:0]       rd_idx;
  logic [RES_W-1:0] res_q;

  logic [7:0] rx_byte, tx_first, tx_next;
  logic [1:0] nidx;
  logic       active;

  assign rx_byte  = {rx_sh[6:0], sda_s};
  assign nidx     = (rd_idx == 2'd3) ? 2'd3 : rd_idx + 2'd1;
  assign tx_first = rd_byte(2'd0, res_q, cfg_rd_i);
  assign tx_next  = rd_byte(nidx, res_q, cfg_rd_i);
  assign active   = (st != ST_IDLE) && (st != ST_SKIP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      nxt     <= ST_IDLE;
      bitcnt  <= '0;
      in_ack  <= 1'b0;
      ack_ok  <= 1'b0;
      mack    <= 1'b0;
      rx_sh   <= '0;
      tx_sh   <= 8'hFF;
      rd_idx  <= '0;
      res_q   <= '0;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_data <= '0;
      gc_rst  <= 1'b0;
      hs_mode <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      gc_rst <= 1'b0;
      if (stop_det) begin
        st      <= ST_IDLE;
        bitcnt  <= '0;
        in_ack  <= 1'b0;
        sda_oe  <= 1'b0;
        hs_mode <= 1'b0;
      end else if (start_det) begin
        st     <= ST_ADDR;
        bitcnt <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else if (active) begin
        if (scl_rise) begin
          if (in_ack) begin
            mack <= ~sda_s;
          end else if (bitcnt < FULL) begin
            bitcnt <= bitcnt + 1'b1;
            if (st != ST_READ) begin
              rx_sh <= rx_byte;
              if (bitcnt == LAST_BIT) begin
                unique case (st)
                  ST_ADDR: begin
                    if (rx_byte[7:1] == DEV_ADDR) begin
                      ack_ok <= 1'b1;
                      nxt    <= rx_byte[0] ? ST_READ : ST_WRITE;
                      if (rx_byte[0]) res_q <= result_i;
                    end else if (rx_byte == GC_ADDR_BYTE) begin
                      ack_ok <= 1'b1;
                      nxt    <= ST_GCALL;
                    end else begin
                      ack_ok <= 1'b0;
                      nxt    <= ST_SKIP;
                      if (is_master_code(rx_byte)) hs_mode <= 1'b1;
                    end
                  end
                  ST_WRITE: begin
                    wr_stb  <= 1'b1;
                    wr_data <= rx_byte;
                    ack_ok  <= 1'b1;
                    nxt     <= ST_WRITE;
                  end
                  ST_GCALL: begin
                    ack_ok <= gc_data_acked(rx_byte);
                    gc_rst <= (rx_byte == GC_RESET_CMD);
                    nxt    <= ST_SKIP;
                  end
                  default: begin
                    ack_ok <= 1'b0;
                    nxt    <= ST_SKIP;
                  end
                endcase
              end
            end
          end
        end else if (scl_fall) begin
          if (in_ack) begin
            in_ack <= 1'b0;
            bitcnt <= '0;
            if (st == ST_READ) begin
              if (mack) begin
                rd_idx <= nidx;
                tx_sh  <= tx_next;
                sda_oe <= (nidx != 2'd3) & ~tx_next[7];
              end else begin
                st     <= ST_SKIP;
                sda_oe <= 1'b0;
              end
            end else begin
              st <= nxt;
              if (nxt == ST_READ) begin
                rd_idx <= 2'd0;
                tx_sh  <= tx_first;
                sda_oe <= ~tx_first[7];
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end else if (bitcnt == FULL) begin
            in_ack <= 1'b1;
            sda_oe <= (st == ST_READ) ? 1'b0 : ack_ok;
          end else if (st == ST_READ && bitcnt != '0) begin
            tx_sh  <= {tx_sh[6:0], 1'b1};
            sda_oe <= (rd_idx != 2'd3) & ~tx_sh[6];
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_conv_target.sv
module i2c_conv_target #(
  parameter logic [6:0] DEV_ADDR    = 7'b1001000,
  parameter int         SYNC_STAGES = 2,
  parameter int         RES_W       = 16,
  parameter int         CFG_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [RES_W-1:0] result_i,
  input  logic [CFG_W-1:0] cfg_rd_i,
  output logic             cfg_wr_o,
  output logic [CFG_W-1:0] cfg_data_o,
  output logic             gc_reset_o,
  output logic             hs_mode_o
);
  // Named internal events, visible to the bound checker.
  logic sda_s_w, scl_rise_w, scl_fall_w, start_w, stop_w;

  i2ct_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s_w),
    .scl_rise  (scl_rise_w),
    .scl_fall  (scl_fall_w),
    .start_det (start_w),
    .stop_det  (stop_w)
  );

  i2ct_ctrl #(.DEV_ADDR(DEV_ADDR), .RES_W(RES_W), .CFG_W(CFG_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s_w),
    .scl_rise  (scl_rise_w),
    .scl_fall  (scl_fall_w),
    .start_det (start_w),
    .stop_det  (stop_w),
    .result_i  (result_i),
    .cfg_rd_i  (cfg_rd_i),
    .sda_oe    (sda_oe_o),
    .wr_stb    (cfg_wr_o),
    .wr_data   (cfg_data_o),
    .gc_rst    (gc_reset_o),
    .hs_mode   (hs_mode_o)
  );
endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_rise,
  input logic scl_fall,
  input logic start_det,
  input logic stop_det,
  input logic sda_oe,
  input logic wr_stb,
  input logic gc_rst,
  input logic hs_mode
);
  // R13
  oe_moves_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_fall || start_det || stop_det) |=> $stable(sda_oe));

  // R2
  stop_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe && !hs_mode);

  // R5
  wr_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(scl_rise));

  // R6
  gc_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gc_rst |-> $past(scl_rise));

  // R7
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && gc_rst));

  // R8
  hs_sets_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_mode) |-> $past(scl_rise));
endmodule

bind i2c_conv_target i2ct_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_rise  (scl_rise_w),
  .scl_fall  (scl_fall_w),
  .start_det (start_w),
  .stop_det  (stop_w),
  .sda_oe    (sda_oe_o),
  .wr_stb    (cfg_wr_o),
  .gc_rst    (gc_reset_o),
  .hs_mode   (hs_mode_o)
);

// File: tb/i2c_conv_target_tb.sv
module i2c_conv_target_tb;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [15:0] result = 16'hA5C3;
  logic [7:0]  cfg = 8'h8C;
  logic cfg_wr, gc_rst, hs;
  logic [7:0] cfg_data;
  wire  sda_bus = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_conv_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .result_i(result), .cfg_rd_i(cfg), .cfg_wr_o(cfg_wr), .cfg_data_o(cfg_data),
    .gc_reset_o(gc_rst), .hs_mode_o(hs)
  );

  int checks = 0, fails = 0;
  int wr_cnt = 0, gc_cnt = 0;
  logic [7:0] wr_last = 8'h00;
  logic watch_quiet = 1'b0, quiet_viol = 1'b0;

  always @(posedge clk) begin
    if (cfg_wr) begin wr_cnt++; wr_last = cfg_data; end
    if (gc_rst) gc_cnt++;
    if (watch_quiet && sda_oe) quiet_viol = 1'b1;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start(); sda_m = 1; scl = 1; wq(); sda_m = 0; wq(); scl = 0; wq(); endtask
  task automatic bus_rstart(); sda_m = 1; wq(); scl = 1; wq(); sda_m = 0; wq(); scl = 0; wq(); endtask
  task automatic bus_stop(); sda_m = 0; wq(); scl = 1; wq(); sda_m = 1; wq(); endtask
  task automatic bus_bit(input logic b, output logic r);
    sda_m = b; wq(); scl = 1; wq(); r = sda_bus; wq(); scl = 0; wq();
  endtask
  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
    bus_bit(1'b1, r);
    ack = ~r;
  endtask
  task automatic rbyte(input logic give_ack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin bus_bit(1'b1, r); b[i] = r; end
    bus_bit(~give_ack, r);
  endtask

  // {addr, data, addr_ack, data_ack, wr_expected, gc_expected}
  localparam int NV = 6;
  localparam logic [19:0] VEC [NV] = '{
    {8'h90, 8'h5A, 1'b1, 1'b1, 1'b1, 1'b0},  // R1 R5 write
    {8'h92, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0},  // R10 foreign address
    {8'h00, 8'h06, 1'b1, 1'b1, 1'b0, 1'b1},  // R6 general-call reset
    {8'h00, 8'h04, 1'b1, 1'b1, 1'b0, 1'b0},  // R7 04h acked, no reset
    {8'h00, 8'h35, 1'b1, 1'b0, 1'b0, 1'b0},  // R7 other byte refused
    {8'h90, 8'hC3, 1'b1, 1'b1, 1'b1, 1'b0}   // R5 second write
  };

  logic done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic a, d;
    logic [7:0] b;
    int w0, g0;
    repeat (5) @(negedge clk);
    // R11 reset state
    chk(sda_oe == 0, "R11 oe", sda_oe, 0);
    chk(hs == 0, "R11 hs", hs, 0);
    chk(cfg_wr == 0 && gc_rst == 0, "R11 strobes", {cfg_wr, gc_rst}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 0, "R11 oe after release", sda_oe, 0);

    for (int v = 0; v < NV; v++) begin
      w0 = wr_cnt; g0 = gc_cnt;
      watch_quiet = ~VEC[v][3]; quiet_viol = 0;
      bus_start();
      wbyte(VEC[v][19:12], a);
      chk(a == VEC[v][3], "R1/R6/R10 addr ack", a, VEC[v][3]);
      wbyte(VEC[v][11:4], d);
      chk(d == VEC[v][2], "R5/R6/R7 data ack", d, VEC[v][2]);
      bus_stop();
      watch_quiet = 0;
      chk(wr_cnt - w0 == int'(VEC[v][1]), "R5 write strobe", wr_cnt - w0, VEC[v][1]);
      if (VEC[v][1]) chk(wr_last == VEC[v][11:4], "R5 write data", wr_last, VEC[v][11:4]);
      chk(gc_cnt - g0 == int'(VEC[v][0]), "R6/R7 gc pulse", gc_cnt - g0, VEC[v][0]);
      if (!VEC[v][3]) chk(!quiet_viol, "R10 never drives", quiet_viol, 0);
      chk(sda_oe == 0, "R2 released after stop", sda_oe, 0);
    end

    // R3 R4 read sequence and extra bytes
    w0 = wr_cnt; g0 = gc_cnt;
    bus_start();
    wbyte(8'h91, a); chk(a, "R1 read addr ack", a, 1);
    rbyte(1, b); chk(b == 8'hA5, "R3 result high", b, 8'hA5);
    rbyte(1, b); chk(b == 8'hC3, "R3 result low", b, 8'hC3);
    rbyte(1, b); chk(b == 8'h8C, "R3 config", b, 8'h8C);
    rbyte(1, b); chk(b == 8'hFF, "R4 fourth byte", b, 8'hFF);
    rbyte(0, b); chk(b == 8'hFF, "R4 fifth byte", b, 8'hFF);
    bus_stop();
    chk(wr_cnt == w0 && gc_cnt == g0, "R4 no side effect", wr_cnt - w0 + gc_cnt - g0, 0);

    // R12 master NACK ends the read
    result = 16'h0F00;
    bus_start();
    wbyte(8'h91, a);
    rbyte(0, b); chk(b == 8'h0F, "R12 first byte", b, 8'h0F);
    quiet_viol = 0; watch_quiet = 1;
    rbyte(1, b); chk(b == 8'hFF, "R12 after nack", b, 8'hFF);
    watch_quiet = 0;
    chk(!quiet_viol, "R12 stays released", quiet_viol, 0);
    bus_stop();

    // R9 repeated start: write then read without stop
    result = 16'h1234;
    w0 = wr_cnt;
    bus_start();
    wbyte(8'h90, a);
    wbyte(8'h11, d);
    bus_rstart();
    wbyte(8'h91, a); chk(a, "R9 read addr after rstart", a, 1);
    rbyte(0, b); chk(b == 8'h12, "R9 read data", b, 8'h12);
    bus_stop();
    chk(wr_cnt - w0 == 1 && wr_last == 8'h11, "R9 write before rstart", wr_last, 8'h11);

    // R8 master code
    quiet_viol = 0; watch_quiet = 1;
    bus_start();
    wbyte(8'h0B, a); chk(!a, "R8 master code nack", a, 0);
    watch_quiet = 0;
    chk(hs == 1, "R8 hs set", hs, 1);
    bus_rstart();
    chk(hs == 1, "R8 hs held over rstart", hs, 1);
    bus_stop();
    repeat (4) @(negedge clk);
    chk(hs == 0, "R2 R8 hs cleared by stop", hs, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule